// File: doc/BRIEF.md
# Transceiver Profile Switch Sequencer

This block keeps a group of bonded serial transceiver channels matched to the orientation of a reversible connector. Two stored channel configurations are kept in the transceiver. Configuration 0 places the bonding master on the low channel and is used for the normal plug orientation. Configuration 1 places the master on the high channel and is used for the flipped orientation. The block is needed most in two-lane operation, because a flip there moves all traffic off the default master channel.

An orientation signal from an external detector is synchronised. Every change of its synchronised value starts a fixed sequence on a simple memory-mapped master bus with address, read, write and waitrequest. The steps are: claim the reconfiguration port, select the new configuration, start recalibration, poll until recalibration is no longer busy, and release the port. The datapath is held in reset for the whole sequence. At the end a single-cycle done pulse is given, so that the lane crossbar can switch its mapping on the same clock. If the poll exceeds a programmable limit, an error flag is raised.

Top module: `xcvr_profile_seq`

## Requirements
- R1: After reset, busy, done, err, dp_reset, cfg_wr and cfg_rd are 0 and active_profile is 0 (normal orientation).
- R2: A sequence starts only when the synchronised orientation changes value. While the orientation is steady the block makes no bus access.
- R3: Each sequence makes its writes in this order. First, data 0x2 to offset 0x000 claims the port. Second, the target configuration is written to offset 0x340. Third, data 0x6 to offset 0x000 starts recalibration. Fourth, after polling ends, data 0x0 to offset 0x000 releases the port.
- R4: The configuration written to offset 0x340 equals the synchronised orientation when the sequence starts: 0 for normal, 1 for flipped.
- R5: While cfg_wait is high during an access, the strobe, cfg_addr and cfg_wdata hold their values. An access completes on the first clock edge at which cfg_wait is low.
- R6: After the recalibration write, the block reads offset 0x000 repeatedly until a read returns bit 0 clear. It then makes the release write.
- R7: If timeout_limit consecutive poll reads all return bit 0 set, polling stops and the release write still follows. A limit of 0 acts as 1. In this case err goes high together with done and active_profile keeps its old value. err returns to 0 when the next sequence starts.
- R8: When a sequence ends, done is high for exactly one cycle. In that same cycle busy falls, and active_profile takes the new configuration unless a timeout occurred.
- R9: dp_reset and busy are high from the start of a sequence until the done cycle, and every bus access lies within that span.
- R10: A change of orientation that arrives while a sequence runs is held. Once the current sequence finishes, another sequence starts, using the orientation value present at that time.
- R11: cfg_rd and cfg_wr are never high together. Writes go only to offsets 0x000 and 0x340, and reads only to offset 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| orient_async | input | 1 | Plug orientation from the detector (1 = flipped), asynchronous |
| timeout_limit | input | TMO_W | Maximum number of consecutive busy poll reads |
| cfg_addr | output | ADDR_W | Reconfiguration bus address |
| cfg_wr | output | 1 | Write strobe |
| cfg_rd | output | 1 | Read strobe |
| cfg_wdata | output | DATA_W | Write data |
| cfg_rdata | input | DATA_W | Read data |
| cfg_wait | input | 1 | Waitrequest: access stalls while high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence ended with a poll timeout |
| dp_reset | output | 1 | Datapath reset, held during the sequence |
| active_profile | output | 1 | Configuration currently applied |

## Verification
The checker tests these properties on every cycle:
- the bus stays stable under waitrequest;
- read and write never occur together, and only legal offsets are used;
- no bus activity occurs outside the dp_reset/busy span;
- done lasts a single cycle, with busy and dp_reset already low;
- err can only rise on a done cycle.

Other behaviour can only be shown by the bench's scenarios, which run against a register model with configurable stalls and busy counts. These scenarios cover the exact order and data of writes and reads, the configuration chosen for each orientation, the timeout that leaves the profile unchanged, and a change made during a sequence that is served afterwards.

// File: rtl/xps_pkg.sv
package xps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_SELECT,
    ST_RECAL,
    ST_POLL,
    ST_FREE
  } seq_st_t;
endpackage

// File: rtl/xps_orient_sync.sv
module xps_orient_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic orient_async,
  output logic orient_s,
  output logic orient_chg
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain      <= '0;
      last       <= 1'b0;
      orient_chg <= 1'b0;
    end else begin
      chain      <= {chain[STAGES-2:0], orient_async};
      last       <= chain[STAGES-1];
      orient_chg <= chain[STAGES-1] != last;
    end
  end

  assign orient_s = last;
endmodule

// File: rtl/xps_bus_master.sv
module xps_bus_master #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_rd,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic              cfg_wr,
  output logic              cfg_rd,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic              cfg_wait,
  output logic              ack,
  output logic [DATA_W-1:0] ack_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_addr  <= '0;
      cfg_wr    <= 1'b0;
      cfg_rd    <= 1'b0;
      cfg_wdata <= '0;
      ack       <= 1'b0;
      ack_rdata <= '0;
    end else begin
      ack <= 1'b0;
      if (cfg_wr || cfg_rd) begin
        if (!cfg_wait) begin
          cfg_wr    <= 1'b0;
          cfg_rd    <= 1'b0;
          ack       <= 1'b1;
          ack_rdata <= cfg_rdata;
        end
      end else if (go) begin
        cfg_addr  <= go_addr;
        cfg_wdata <= go_rd ? '0 : go_wdata;
        cfg_rd    <= go_rd;
        cfg_wr    <= !go_rd;
      end
    end
  end
endmodule

// File: rtl/xps_seq_fsm.sv
module xps_seq_fsm
  import xps_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          DATA_W    = 32,
  parameter int          TMO_W     = 8,
  parameter int          BUSY_BIT  = 0,
  parameter [ADDR_W-1:0] CTRL_OFS  = 10'h000,
  parameter [ADDR_W-1:0] PROF_OFS  = 10'h340,
  parameter [DATA_W-1:0] CLAIM_VAL = 32'h2,
  parameter [DATA_W-1:0] RECAL_VAL = 32'h6,
  parameter [DATA_W-1:0] FREE_VAL  = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              orient_s,
  input  logic              orient_chg,
  input  logic [TMO_W-1:0]  timeout_limit,
  input  logic              ack,
  input  logic [DATA_W-1:0] ack_rdata,
  output logic              go,
  output logic              go_rd,
  output logic [ADDR_W-1:0] go_addr,
  output logic [DATA_W-1:0] go_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              dp_reset,
  output logic              active_profile
);
  seq_st_t          state;
  logic             pend;
  logic             target;
  logic             tmo;
  logic [TMO_W-1:0] poll_cnt;
  logic [TMO_W:0]   next_cnt;

  assign next_cnt = {1'b0, poll_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      pend           <= 1'b0;
      target         <= 1'b0;
      tmo            <= 1'b0;
      poll_cnt       <= '0;
      go             <= 1'b0;
      go_rd          <= 1'b0;
      go_addr        <= '0;
      go_wdata       <= '0;
      busy           <= 1'b0;
      done           <= 1'b0;
      err            <= 1'b0;
      dp_reset       <= 1'b0;
      active_profile <= 1'b0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      if (orient_chg) pend <= 1'b1;
      unique case (state)
        ST_IDLE: if (pend) begin
          pend     <= orient_chg;
          target   <= orient_s;
          busy     <= 1'b1;
          dp_reset <= 1'b1;
          err      <= 1'b0;
          tmo      <= 1'b0;
          go       <= 1'b1;
          go_rd    <= 1'b0;
          go_addr  <= CTRL_OFS;
          go_wdata <= CLAIM_VAL;
          state    <= ST_CLAIM;
        end
        ST_CLAIM: if (ack) begin
          go       <= 1'b1;
          go_rd    <= 1'b0;
          go_addr  <= PROF_OFS;
          go_wdata <= {{(DATA_W-1){1'b0}}, target};
          state    <= ST_SELECT;
        end
        ST_SELECT: if (ack) begin
          go       <= 1'b1;
          go_rd    <= 1'b0;
          go_addr  <= CTRL_OFS;
          go_wdata <= RECAL_VAL;
          state    <= ST_RECAL;
        end
        ST_RECAL: if (ack) begin
          go       <= 1'b1;
          go_rd    <= 1'b1;
          go_addr  <= CTRL_OFS;
          poll_cnt <= '0;
          state    <= ST_POLL;
        end
        ST_POLL: if (ack) begin
          go      <= 1'b1;
          go_addr <= CTRL_OFS;
          if (!ack_rdata[BUSY_BIT]) begin
            go_rd    <= 1'b0;
            go_wdata <= FREE_VAL;
            state    <= ST_FREE;
          end else if (next_cnt >= {1'b0, timeout_limit}) begin
            tmo      <= 1'b1;
            go_rd    <= 1'b0;
            go_wdata <= FREE_VAL;
            state    <= ST_FREE;
          end else begin
            poll_cnt <= next_cnt[TMO_W-1:0];
            go_rd    <= 1'b1;
          end
        end
        ST_FREE: if (ack) begin
          done     <= 1'b1;
          busy     <= 1'b0;
          dp_reset <= 1'b0;
          err      <= tmo;
          if (!tmo) active_profile <= target;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_profile_seq.sv
module xcvr_profile_seq #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int TMO_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              orient_async,
  input  logic [TMO_W-1:0]  timeout_limit,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic              cfg_wr,
  output logic              cfg_rd,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic              cfg_wait,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              dp_reset,
  output logic              active_profile
);
  logic              orient_s, orient_chg;
  logic              go, go_rd, ack;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_wdata, ack_rdata;

  xps_orient_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .orient_async(orient_async),
    .orient_s(orient_s), .orient_chg(orient_chg)
  );

  xps_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) u_fsm (
    .clk(clk), .rst(rst), .orient_s(orient_s), .orient_chg(orient_chg),
    .timeout_limit(timeout_limit), .ack(ack), .ack_rdata(ack_rdata),
    .go(go), .go_rd(go_rd), .go_addr(go_addr), .go_wdata(go_wdata),
    .busy(busy), .done(done), .err(err), .dp_reset(dp_reset),
    .active_profile(active_profile)
  );

  xps_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .go(go), .go_rd(go_rd), .go_addr(go_addr),
    .go_wdata(go_wdata), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_wait(cfg_wait), .ack(ack), .ack_rdata(ack_rdata)
  );
endmodule

// File: rtl/xps_profile_seq_chk.sv
module xps_profile_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              cfg_wait,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              dp_reset
);
  assert_hold_under_wait_R5: assert property (@(posedge clk) disable iff (rst)
    ((cfg_wr || cfg_rd) && cfg_wait) |=>
      ($stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_wr) && $stable(cfg_rd)));

  assert_no_rd_wr_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && cfg_rd));

  assert_legal_write_ofs_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |-> (cfg_addr == 10'h000 || cfg_addr == 10'h340));

  assert_legal_read_ofs_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |-> (cfg_addr == 10'h000));

  assert_bus_inside_reset_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr || cfg_rd) |-> (dp_reset && busy));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !dp_reset && $past(busy)));

  assert_err_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);
endmodule

bind xcvr_profile_seq xps_profile_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_wdata(cfg_wdata), .cfg_wait(cfg_wait), .busy(busy), .done(done),
  .err(err), .dp_reset(dp_reset)
);

// File: tb/xcvr_profile_seq_bench.sv
`timescale 1ns/1ps
module xcvr_profile_seq_bench;
  localparam int AW = 10, DW = 32, TW = 8;

  logic          clk = 1'b0, rst = 1'b1, orient = 1'b0;
  logic [TW-1:0] limit = 8'd8;
  logic [AW-1:0] cfg_addr;
  logic          cfg_wr, cfg_rd, cfg_wait = 1'b0;
  logic [DW-1:0] cfg_wdata, cfg_rdata = '0;
  logic          busy, done, err, dp_reset, active_profile;

  int checks = 0, failures = 0;
  int stall_cfg = 0, stall_left = 0, busy_left = 0, dones = 0;
  logic [AW+DW:0] exp_q[$];

  always #2 clk = ~clk;

  xcvr_profile_seq u_xcvr_profile_seq (
    .clk(clk), .rst(rst), .orient_async(orient), .timeout_limit(limit),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_wait(cfg_wait), .busy(busy), .done(done),
    .err(err), .dp_reset(dp_reset), .active_profile(active_profile)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_w(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back({1'b0, a, d});
  endtask

  task automatic push_r(input bit b);
    exp_q.push_back({1'b1, 10'h000, 31'd0, b});
  endtask

  // driver: expected transactions of one sequence (R3, R4, R6, R7)
  task automatic exp_seq(input bit prof, input int nbusy, input int lim_in);
    int lim = (lim_in == 0) ? 1 : lim_in;
    push_w(10'h000, 32'h2);
    push_w(10'h340, {31'd0, prof});
    push_w(10'h000, 32'h6);
    if (nbusy < lim) begin
      for (int i = 0; i < nbusy; i++) push_r(1'b1);
      push_r(1'b0);
    end else begin
      for (int i = 0; i < lim; i++) push_r(1'b1);
    end
    push_w(10'h000, 32'h0);
  endtask

  // register model and monitor
  always @(negedge clk) begin
    if (rst) begin
      cfg_wait   = 1'b0;
      stall_left = stall_cfg;
    end else begin
      if (done) begin
        dones++;
        chk(!busy && !dp_reset, "R8 done with busy/dp_reset low", {busy, dp_reset}, 0);
      end
      if (cfg_wr || cfg_rd) begin
        if (stall_left > 0) begin
          cfg_wait = 1'b1;
          stall_left--;
        end else begin
          logic [AW+DW:0] item, exp_item;
          cfg_wait = 1'b0;
          if (cfg_rd) begin
            cfg_rdata = {31'd0, busy_left > 0};
            if (busy_left > 0) busy_left--;
            item = {1'b1, cfg_addr, cfg_rdata};
          end else begin
            item = {1'b0, cfg_addr, cfg_wdata};
          end
          chk(dp_reset, "R9 dp_reset during access", dp_reset, 1);
          if (exp_q.size() == 0) begin
            chk(0, "R2/R3 unexpected access", item, 0);
          end else begin
            exp_item = exp_q.pop_front();
            chk(item == exp_item, "R3/R5/R6 transaction", item, exp_item);
          end
          stall_left = stall_cfg;
        end
      end else begin
        cfg_wait   = 1'b0;
        stall_left = stall_cfg;
      end
    end
  end

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R8 sequence completes", done, 1);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err && !dp_reset && !cfg_wr && !cfg_rd && !active_profile,
        "R1 reset state", {busy, done, err, dp_reset, cfg_wr, cfg_rd, active_profile}, 0);
    rst = 1'b0;

    // R2: steady orientation gives no activity
    repeat (40) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R2 idle without change", busy, 0);

    // flip: profile 1, stalls, two busy polls
    stall_cfg = 2; busy_left = 2; limit = 8'd8;
    exp_seq(1'b1, 2, 8);
    orient = 1'b1;
    wait_done();
    chk(active_profile == 1'b1, "R4 R8 profile after flip", active_profile, 1);
    chk(err == 1'b0, "R6 no error when busy clears", err, 0);
    @(negedge clk);
    chk(!done, "R8 done single cycle", done, 0);
    chk(exp_q.size() == 0, "R3 all transactions seen", exp_q.size(), 0);

    // steady again: no further activity
    repeat (40) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R2 no restart without change", busy, 0);

    // back to normal, no stalls, busy clears at once
    stall_cfg = 0; busy_left = 0;
    exp_seq(1'b0, 0, 8);
    orient = 1'b0;
    wait_done();
    chk(active_profile == 1'b0, "R4 profile after unflip", active_profile, 0);
    chk(dp_reset == 1'b0, "R9 dp_reset released at done", dp_reset, 0);

    // timeout: three busy reads, then release and error
    stall_cfg = 1; busy_left = 100; limit = 8'd3;
    exp_seq(1'b1, 100, 3);
    orient = 1'b1;
    wait_done();
    chk(err == 1'b1, "R7 timeout error", err, 1);
    chk(active_profile == 1'b0, "R7 profile kept on timeout", active_profile, 0);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && !busy, "R7 release after timeout", exp_q.size(), 0);

    // R10: change during busy is held and served after
    busy_left = 1; limit = 8'd8; stall_cfg = 3;
    exp_seq(1'b0, 1, 8);
    exp_seq(1'b1, 0, 8);
    orient = 1'b0;
    while (!busy) @(negedge clk);
    chk(err == 1'b0, "R7 err cleared at next start", err, 1'b0);
    repeat (6) @(negedge clk);
    orient = 1'b1;
    wait_done();
    chk(active_profile == 1'b0, "R10 first sequence target", active_profile, 0);
    wait_done();
    chk(active_profile == 1'b1, "R10 held change served", active_profile, 1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && !busy, "R10 no extra sequence", exp_q.size(), 0);
    chk(dones == 5, "R8 done count", dones, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule